// File: doc/BRIEF.md
# Byte-Parallel Configuration Serializer

This block sits between a host processor's asynchronous write port and a one-bit configuration stream. The host places a byte on an 8-bit bus and pulses a write strobe qualified by two chip selects of opposite polarity. When the strobe ends, the block takes the byte and sends it out one bit per configuration clock, most significant bit first. The serial line changes on the falling clock edge, so a receiver can sample it on the rising edge.

While a byte drains, `ready` is low. The host either watches `ready` or polls it by pulling the read strobe low. During a read the block drives the ready status onto the top bit of the bus through an enable, and it never drives the lower seven bits. A write that starts while the block is busy is discarded and sets a sticky `overrun` flag. Only reset clears that flag.

Control is a four-state machine:
- IDLE: waiting for a qualified write.
- ARMED: a qualified write is present and the byte is being latched.
- SHIFT: the byte drains onto the serial line.
- WAIT_REL: a write that was rejected is still held when the drain ends, and the machine waits for it to be released.

The transitions are:
- IDLE→ARMED when the qualified write is seen.
- ARMED→SHIFT when it is released, which loads the byte.
- SHIFT→IDLE after the last bit when no write is held.
- SHIFT→WAIT_REL after the last bit while a write is still held.
- WAIT_REL→IDLE when that write is released.

Top module: `cfg_byte_loader`

## Requirements
- R1: A write is qualified only when `host_wr_n`=0, `sel_lo_n`=0 and `sel_hi`=1 at the same time. Any other combination, held and then removed, leaves `ready`=1 and `ser_out`=1.
- R2: The byte is taken when a qualified write ends. The host holds the data until `ready` falls. With the strobe released just after a falling edge, `ready` is still 1 at the next two rising edges and falls at the third.
- R3: After a byte is taken, `ready` stays low for exactly 8 clock periods, which is within the allowed 1 to 8. It rises at the rising edge after the last bit has been placed on the line.
- R4: The bits appear on `ser_out` MSB first. Each bit changes on a falling clock edge and is held for one full period. Bit 7 appears at the falling edge that follows the rising edge where `ready` fell.
- R5: After reset `ready`=1, `ser_out`=1 and `overrun`=0. `ser_out` stays 1 whenever no byte is draining.
- R6: `top_bit_oe` is 1 two rising edges after `host_rd_n` goes low and 0 otherwise. While it is 1, `top_bit_val` equals `ready`; while it is 0, `top_bit_val` is 0.
- R7: A qualified write whose start is seen during SHIFT is ignored. The byte in progress drains unchanged, no second busy period follows, and `overrun` goes to 1 and stays there until reset. This holds whether the ignored write ends during SHIFT or after it.
- R8: A write that starts after `ready` has returned high is accepted normally. A run of bytes written one after another is serialized without loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_d | input | 8 | Host data bus (write data) |
| host_wr_n | input | 1 | Write strobe, active low, asynchronous |
| host_rd_n | input | 1 | Read strobe, active low, asynchronous |
| sel_lo_n | input | 1 | Chip select, active low |
| sel_hi | input | 1 | Chip select, active high |
| ready | output | 1 | High when a new byte may be written |
| ser_out | output | 1 | Serial configuration data, changes on falling clock edge |
| top_bit_oe | output | 1 | Output enable for the top data bit readback |
| top_bit_val | output | 1 | Value driven on the top data bit during a read |
| overrun | output | 1 | Sticky flag, a write arrived while busy |

## Verification
The embedded properties check on every cycle the following:
- Busy never lasts past eight periods.
- `ready` falls only on the release of an armed write.
- The serial line is high whenever the block has been idle for a full period.
- `overrun` is sticky and rises only out of SHIFT.

The bench's scenarios cover what those properties cannot express:
- The exact bit order and edge placement, by sweeping all 256 byte values.
- Rejection of every non-qualifying select/strobe combination.
- The readback of `ready` on the top bit during a transfer.
- That rejected writes, whether released inside or after the drain, leave the serial stream and the following handshake unchanged.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ARMED    = 2'd1,
        ST_SHIFT    = 2'd2,
        ST_WAIT_REL = 2'd3
    } ld_state_t;

    // bit positions of the control inputs inside the synchronizer vector
    localparam int CTL_WR  = 0;
    localparam int CTL_SLO = 1;
    localparam int CTL_SHI = 2;
    localparam int CTL_RD  = 3;
    localparam int CTL_W   = 4;

    // idle (inactive) levels: rd_n=1, sel_hi=0, sel_lo_n=1, wr_n=1
    localparam logic [CTL_W-1:0] CTL_IDLE = 4'b1011;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int          WIDTH   = 4,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain[i] <= RST_VAL;
            end
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/cfg_ser_shifter.sv
module cfg_ser_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              active,
    input  logic [DATA_W-1:0] load_data,
    output logic              ser_out,
    output logic              last_bit
);

    localparam int              CNT_W    = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_idx;
    logic              line_q;

    // rising edge: load or advance the shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_idx <= '0;
        end else if (load) begin
            shreg   <= load_data;
            bit_idx <= '0;
        end else if (active) begin
            shreg   <= {shreg[DATA_W-2:0], 1'b0};
            bit_idx <= bit_idx + 1'b1;
        end
    end

    // falling edge: present the current MSB, line rests high when idle
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= 1'b1;
        end else if (active) begin
            line_q <= shreg[DATA_W-1];
        end else begin
            line_q <= 1'b1;
        end
    end

    assign ser_out  = line_q;
    assign last_bit = active && (bit_idx == LAST_IDX);

    // R5: a full idle period leaves the line high
    assert_idle_line_high_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!active && !$past(active)) |-> ser_out
    );

endmodule

// File: rtl/cfg_ctrl_fsm.sv
module cfg_ctrl_fsm
    import cfg_loader_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  logic [DATA_W-1:0] host_d,
    input  logic              last_bit,
    output logic              ready,
    output logic              active,
    output logic              load,
    output logic [DATA_W-1:0] held_byte,
    output logic              overrun
);

    localparam int               LEN_W     = $clog2(DATA_W) + 1;
    localparam logic [LEN_W-1:0] LEN_LIMIT = LEN_W'(DATA_W);
    localparam logic [LEN_W-1:0] LEN_LAST  = LEN_W'(DATA_W - 1);

    ld_state_t  state, state_nx;
    logic       wr_go_d;
    logic       ovr_q;
    logic [DATA_W-1:0] hold_q;
    logic [LEN_W-1:0]  busy_len;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (wr_go)    state_nx = ST_ARMED;
            ST_ARMED:    if (!wr_go)   state_nx = ST_SHIFT;
            ST_SHIFT:    if (last_bit) state_nx = wr_go ? ST_WAIT_REL : ST_IDLE;
            ST_WAIT_REL: if (!wr_go)   state_nx = ST_IDLE;
            default:                   state_nx = ST_IDLE;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        ready  = 1'b1;
        active = 1'b0;
        load   = 1'b0;
        unique case (state)
            ST_IDLE:     ready = 1'b1;
            ST_ARMED:    load  = !wr_go;
            ST_SHIFT: begin
                ready  = 1'b0;
                active = 1'b1;
            end
            ST_WAIT_REL: ready = 1'b1;
            default:     ready = 1'b1;
        endcase
    end

    // byte latch, strobe history and sticky overrun
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= '0;
            wr_go_d <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            wr_go_d <= wr_go;
            if (wr_go && (state == ST_IDLE || state == ST_ARMED)) begin
                hold_q <= host_d;
            end
            if (state == ST_SHIFT && wr_go && !wr_go_d) begin
                ovr_q <= 1'b1;
            end
        end
    end

    assign held_byte = hold_q;
    assign overrun   = ovr_q;

    // cycle count of the current busy period, for the bound check
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_len <= '0;
        end else if (state == ST_SHIFT) begin
            busy_len <= busy_len + 1'b1;
        end else begin
            busy_len <= '0;
        end
    end

    // R3: busy never reaches the limit, and leaves after the last period
    assert_busy_bounded_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |-> (busy_len < LEN_LIMIT)
    );
    assert_busy_ends_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && busy_len == LEN_LAST) |=> (state != ST_SHIFT)
    );

    // R2: ready only falls on the release of an armed write
    assert_ready_fall_on_release_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> ($past(state) == ST_ARMED && !$past(wr_go))
    );

    // R7: overrun is sticky and is raised only while draining
    assert_overrun_sticky_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        overrun |=> overrun
    );
    assert_overrun_cause_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> ($past(state) == ST_SHIFT)
    );

endmodule

// File: rtl/cfg_byte_loader.sv
module cfg_byte_loader
    import cfg_loader_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              cfg_clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] host_d,
    input  logic              host_wr_n,
    input  logic              host_rd_n,
    input  logic              sel_lo_n,
    input  logic              sel_hi,
    output logic              ready,
    output logic              ser_out,
    output logic              top_bit_oe,
    output logic              top_bit_val,
    output logic              overrun
);

    logic [CTL_W-1:0]  ctl_raw, ctl_s;
    logic              wr_go, load, active, last_bit, rdy_i;
    logic [DATA_W-1:0] held_byte;

    always_comb begin
        ctl_raw          = CTL_IDLE;
        ctl_raw[CTL_WR]  = host_wr_n;
        ctl_raw[CTL_SLO] = sel_lo_n;
        ctl_raw[CTL_SHI] = sel_hi;
        ctl_raw[CTL_RD]  = host_rd_n;
    end

    cfg_sync #(
        .WIDTH  (CTL_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(CTL_IDLE)
    ) u_sync (
        .clk     (cfg_clk),
        .rst_n   (rst_n),
        .async_in(ctl_raw),
        .sync_out(ctl_s)
    );

    // write is qualified only with all three strobes asserted
    assign wr_go = !ctl_s[CTL_WR] && !ctl_s[CTL_SLO] && ctl_s[CTL_SHI];

    cfg_ctrl_fsm #(
        .DATA_W(DATA_W)
    ) u_fsm (
        .clk      (cfg_clk),
        .rst_n    (rst_n),
        .wr_go    (wr_go),
        .host_d   (host_d),
        .last_bit (last_bit),
        .ready    (rdy_i),
        .active   (active),
        .load     (load),
        .held_byte(held_byte),
        .overrun  (overrun)
    );

    cfg_ser_shifter #(
        .DATA_W(DATA_W)
    ) u_shift (
        .clk      (cfg_clk),
        .rst_n    (rst_n),
        .load     (load),
        .active   (active),
        .load_data(held_byte),
        .ser_out  (ser_out),
        .last_bit (last_bit)
    );

    assign ready       = rdy_i;
    assign top_bit_oe  = !ctl_s[CTL_RD];
    assign top_bit_val = top_bit_oe && rdy_i;

endmodule

// File: tb/cfg_byte_loader_tb_top.sv
module cfg_byte_loader_tb_top;

    logic       cfg_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] host_d = 8'h00;
    logic       host_wr_n = 1'b1;
    logic       host_rd_n = 1'b1;
    logic       sel_lo_n = 1'b1;
    logic       sel_hi = 1'b0;
    logic       ready, ser_out, top_bit_oe, top_bit_val, overrun;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 cfg_clk = ~cfg_clk;

    cfg_byte_loader dut_i (
        .cfg_clk    (cfg_clk),
        .rst_n      (rst_n),
        .host_d     (host_d),
        .host_wr_n  (host_wr_n),
        .host_rd_n  (host_rd_n),
        .sel_lo_n   (sel_lo_n),
        .sel_hi     (sel_hi),
        .ready      (ready),
        .ser_out    (ser_out),
        .top_bit_oe (top_bit_oe),
        .top_bit_val(top_bit_val),
        .overrun    (overrun)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    task automatic strobe_on(input logic [7:0] b);
        host_d = b; host_wr_n = 1'b0; sel_lo_n = 1'b0; sel_hi = 1'b1;
    endtask

    task automatic strobe_off;
        host_wr_n = 1'b1; sel_lo_n = 1'b1; sel_hi = 1'b0;
    endtask

    // mode 0: plain write; 1: second write inside the drain; 2: second write held past it
    task automatic run_byte(input logic [7:0] b, input int mode, input logic rd_on);
        int exp_rdy;
        @(negedge cfg_clk);
        host_rd_n = !rd_on;
        strobe_on(b);
        repeat (3) @(negedge cfg_clk);
        strobe_off();
        for (int k = 1; k <= 11; k++) begin
            @(posedge cfg_clk); #5;
            exp_rdy = (k >= 3 && k <= 10) ? 0 : 1;
            if (k < 3) check("R2", ready, 1);
            else       check("R3", ready, exp_rdy);
            if (k >= 4) check("R4", ser_out, b[11-k]);
            else        check("R5", ser_out, 1);
            check("R6", top_bit_oe, rd_on);
            check("R6", top_bit_val, rd_on ? exp_rdy : 0);
            @(negedge cfg_clk);
            if (mode == 1 && k == 4) strobe_on(~b);
            if (mode == 1 && k == 7) strobe_off();
            if (mode == 2 && k == 6) strobe_on(~b);
        end
        if (mode == 2) begin
            repeat (2) @(negedge cfg_clk);
            strobe_off();
        end
        for (int j = 0; j < 8; j++) begin
            @(posedge cfg_clk); #5;
            if (mode == 0) begin
                check("R8", ready, 1);
                check("R8", ser_out, 1);
            end else begin
                check("R7", ready, 1);
                check("R7", ser_out, 1);
                check("R7", overrun, 1);
            end
        end
    endtask

    task automatic do_reset;
        @(negedge cfg_clk);
        rst_n = 1'b0;
        strobe_off();
        host_rd_n = 1'b1;
        repeat (2) @(negedge cfg_clk);
        check("R5", ready, 1);
        check("R5", ser_out, 1);
        check("R5", overrun, 0);
        check("R6", top_bit_oe, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge cfg_clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        repeat (3) @(negedge cfg_clk);

        // R1: every non-qualifying strobe/select combination is rejected
        for (int c = 0; c < 8; c++) begin
            if (c == 3'b001) continue;
            @(negedge cfg_clk);
            host_d = 8'hA5;
            host_wr_n = c[2]; sel_lo_n = c[1]; sel_hi = c[0];
            repeat (4) @(negedge cfg_clk);
            strobe_off();
            for (int j = 0; j < 6; j++) begin
                @(posedge cfg_clk); #5;
                check("R1", ready, 1);
                check("R1", ser_out, 1);
            end
        end

        // R6: readback while idle, then enable removal
        @(negedge cfg_clk);
        host_rd_n = 1'b0;
        @(posedge cfg_clk); #5;
        check("R6", top_bit_oe, 0);
        @(posedge cfg_clk); #5;
        check("R6", top_bit_oe, 1);
        check("R6", top_bit_val, 1);
        @(negedge cfg_clk);
        host_rd_n = 1'b1;
        repeat (2) @(posedge cfg_clk);
        #5;
        check("R6", top_bit_oe, 0);
        check("R6", top_bit_val, 0);

        // R4 / R8: every byte value, alternating readback
        for (int v = 0; v < 256; v++) begin
            run_byte(8'(v), 0, v[0]);
        end
        check("R7", overrun, 0);

        // R7: write inside the drain, then one held past it
        run_byte(8'h3C, 1, 1'b0);
        run_byte(8'hC6, 2, 1'b1);
        // R8: normal write still accepted, flag stays set
        run_byte(8'h81, 0, 1'b0);
        check("R7", overrun, 1);

        // R5: reset clears the flag
        do_reset();
        repeat (3) @(negedge cfg_clk);
        run_byte(8'h5A, 0, 1'b1);
        check("R5", overrun, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule